// File: doc/BRIEF.md
# Three-Level Hybrid Leg Gate Sequencer

This block drives the six switches of one leg of a three-level inverter that uses two switching rates. It takes a signed modulation sample and a triangular carrier value on every clock. Four slow switches select which half of the DC bus the leg works from, and they change only when the modulation changes sign. Two fast switches form a complementary pair that chops between the active level and the neutral level by comparing the modulation magnitude with the carrier. The carrier normally runs at about 10 kHz.

The sign decision has a hysteresis band around zero, so noise near a crossing cannot make the half-cycle decision toggle. When the half-cycle changes, the slow switches move through a fixed staggered order, with a programmable number of clock cycles between each step. This keeps the outer switch of a group from being on without its inner partner, so no inner device has to block the full bus. The fast pair stays off for the whole crossover. When the fast pair changes over, both switches stay off for a programmable dead time. While enable is low, every gate is held off and the sequencer returns to a safe idle state.

Gate bit mapping on `gate_o`:

| Bit | Switch |
|-----|--------|
| 0 | S1, outer switch of the positive group |
| 1 | S2, inner switch of the negative group |
| 2 | S3, inner switch of the positive group |
| 3 | S4, outer switch of the negative group |
| 4 | S5, fast switch to the positive rail path |
| 5 | S6, fast switch to the negative rail path |

Top module: `tl_leg_sequencer`

## Requirements
- R1: While reset is high, and one clock edge after enable is sampled low, all six bits of `gate_o` are 0 and `half_pos_o` is 0.
- R2: On the first edge with enable high, `half_pos_o` takes the sign of `mod_i`: it becomes 1 when `mod_i >= 0` and 0 when `mod_i < 0`. After that, it becomes 1 only when `mod_i > HYST` and becomes 0 only when `mod_i < -HYST`. Values inside the band, including exactly ±HYST, leave it unchanged.
- R3: In the steady positive half, S1 and S3 (bits 0 and 2) are on and S2 and S4 are off. In the steady negative half, S2 and S4 (bits 1 and 3) are on and S1 and S3 are off.
- R4: S1 and S2 are never on together. S3 and S4 are never on together. S5 and S6 are never on together.
- R5: A positive-to-negative crossover switches S1 off, then S3 off, then S2 on, then S4 on. A negative-to-positive crossover switches S4 off, then S2 off, then S3 on, then S1 on. In both cases consecutive steps are exactly SLOW_DLY cycles apart.
- R6: S5 and S6 are both off whenever the slow switches are not in a complete group, that is, S1 and S3 on together or S2 and S4 on together.
- R7: In the steady positive half, S5 is selected when `mod_i > carrier_i` and S6 otherwise. In the steady negative half, S6 is selected when `-mod_i > carrier_i` and S5 otherwise. Both comparisons are strict.
- R8: When the fast selection changes and the inputs then stay stable, both fast gates are off for exactly DEAD cycles between the fall of one and the rise of the other. The gap is never shorter than DEAD cycles.
- R9: If the half-cycle decision reverses during a crossover, the sequence still runs through the all-off step. It then enters the group that matches the current half-cycle, so the other group's switches never turn on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low forces all gates off |
| mod_i | input | MOD_W | Signed modulation sample, two's complement |
| carrier_i | input | MOD_W-1 | Unsigned triangular carrier value |
| gate_o | output | 6 | Gate commands, bit mapping as in the table above |
| half_pos_o | output | 1 | 1 while the positive half-cycle is selected |

## Verification
Random modulation and carrier pairs are applied within each half-cycle. These separate the positive compare from the mirrored negative compare. Directed values set the carrier equal to the modulation magnitude and one below it, which catches a compare that is not strict. Slow ramps through ±HYST and one step past the band show whether the hysteresis thresholds are correct. A single sign step in each direction measures the spacing of every crossover step. A reversal placed in the middle of a crossover shows that the sequence never passes into the wrong group. A single isolated carrier step measures the exact dead-time gap. Holding enable low, and dropping enable in steady state, shows that the gates are released within one cycle and that the next start takes its half-cycle from the sign of the modulation.

// File: rtl/tl_leg_pkg.sv
package tl_leg_pkg;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_P_IN,
    SQ_POS,
    SQ_P_OUT,
    SQ_GAP,
    SQ_N_IN,
    SQ_NEG,
    SQ_N_OUT
  } sq_state_t;

  // slow gate vector: bit0 S1, bit1 S2, bit2 S3, bit3 S4
  function automatic logic [3:0] slow_gates(sq_state_t s);
    logic [3:0] g;
    case (s)
      SQ_P_IN, SQ_P_OUT: g = 4'b0100;
      SQ_POS:            g = 4'b0101;
      SQ_N_IN, SQ_N_OUT: g = 4'b0010;
      SQ_NEG:            g = 4'b1010;
      default:           g = 4'b0000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/tl_half_detect.sv
module tl_half_detect #(
  parameter int MOD_W = 12,
  parameter int HYST  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic signed [MOD_W-1:0] mod_i,
  output logic                    half_o,
  output logic                    valid_o
);

  localparam logic signed [MOD_W:0] HI = (MOD_W+1)'(HYST);
  localparam logic signed [MOD_W:0] LO = -HI;

  logic signed [MOD_W:0] m_x;
  assign m_x = {mod_i[MOD_W-1], mod_i};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_o  <= 1'b0;
      valid_o <= 1'b0;
    end else if (!valid_o) begin
      valid_o <= 1'b1;
      half_o  <= ~mod_i[MOD_W-1];
    end else if (half_o && (m_x < LO)) begin
      half_o <= 1'b0;
    end else if (!half_o && (m_x > HI)) begin
      half_o <= 1'b1;
    end
  end

endmodule

// File: rtl/tl_slow_seq.sv
module tl_slow_seq
  import tl_leg_pkg::*;
#(
  parameter int SLOW_DLY = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       half_valid,
  input  logic       half_pos,
  output logic [3:0] gates_o,
  output logic       steady_nx,
  output logic       pos_nx
);

  localparam int CW = (SLOW_DLY < 2) ? 1 : $clog2(SLOW_DLY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(SLOW_DLY - 1);

  sq_state_t state, state_d;
  logic [CW-1:0] cnt;
  logic          done;

  assign done = (cnt == '0);

  always_comb begin
    state_d = state;
    if (!run) begin
      state_d = SQ_OFF;
    end else begin
      case (state)
        SQ_OFF:   if (half_valid) state_d = half_pos ? SQ_P_IN : SQ_N_IN;
        SQ_P_IN:  if (done) state_d = SQ_POS;
        SQ_POS:   if (!half_pos) state_d = SQ_P_OUT;
        SQ_P_OUT: if (done) state_d = SQ_GAP;
        SQ_GAP:   if (done) state_d = half_pos ? SQ_P_IN : SQ_N_IN;
        SQ_N_IN:  if (done) state_d = SQ_NEG;
        SQ_NEG:   if (half_pos) state_d = SQ_N_OUT;
        SQ_N_OUT: if (done) state_d = SQ_GAP;
        default:  state_d = SQ_OFF;
      endcase
    end
  end

  assign steady_nx = (state_d == SQ_POS) || (state_d == SQ_NEG);
  assign pos_nx    = (state_d == SQ_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_OFF;
      cnt     <= '0;
      gates_o <= '0;
    end else begin
      state   <= state_d;
      gates_o <= slow_gates(state_d);
      if (state_d != state) cnt <= RELOAD;
      else if (!done)       cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/tl_fast_pair.sv
module tl_fast_pair #(
  parameter int MOD_W = 12,
  parameter int DEAD  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    steady,
  input  logic                    pos,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [MOD_W-2:0]        carrier_i,
  output logic                    s5_o,
  output logic                    s6_o
);

  localparam int DW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);
  localparam logic [DW-1:0] RELOAD = DW'(DEAD - 1);

  logic signed [MOD_W:0] m_x, nm_x, c_x;
  logic want5, sel5;
  logic [DW-1:0] cnt;

  assign m_x  = {mod_i[MOD_W-1], mod_i};
  assign nm_x = -m_x;
  assign c_x  = {2'b00, carrier_i};
  assign want5 = pos ? (m_x > c_x) : !(nm_x > c_x);

  always_ff @(posedge clk) begin
    if (rst) begin
      s5_o <= 1'b0;
      s6_o <= 1'b0;
      sel5 <= 1'b0;
      cnt  <= RELOAD;
    end else if (!run || !steady) begin
      s5_o <= 1'b0;
      s6_o <= 1'b0;
      sel5 <= want5;
      cnt  <= RELOAD;
    end else if (want5 != sel5) begin
      s5_o <= 1'b0;
      s6_o <= 1'b0;
      sel5 <= want5;
      cnt  <= RELOAD;
    end else if (cnt != '0) begin
      s5_o <= 1'b0;
      s6_o <= 1'b0;
      cnt  <= cnt - 1'b1;
    end else begin
      s5_o <= sel5;
      s6_o <= !sel5;
    end
  end

endmodule

// File: rtl/tl_leg_sequencer.sv
module tl_leg_sequencer #(
  parameter int MOD_W    = 12,
  parameter int HYST     = 16,
  parameter int SLOW_DLY = 8,
  parameter int DEAD     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [MOD_W-2:0]        carrier_i,
  output logic [5:0]              gate_o,
  output logic                    half_pos_o
);

  logic       half, half_valid;
  logic [3:0] slow_g;
  logic       steady_nx, pos_nx;
  logic       s5, s6;

  tl_half_detect #(.MOD_W(MOD_W), .HYST(HYST)) u_detect (
    .clk(clk), .rst(rst), .run(enable), .mod_i(mod_i),
    .half_o(half), .valid_o(half_valid)
  );

  tl_slow_seq #(.SLOW_DLY(SLOW_DLY)) u_slow (
    .clk(clk), .rst(rst), .run(enable),
    .half_valid(half_valid), .half_pos(half),
    .gates_o(slow_g), .steady_nx(steady_nx), .pos_nx(pos_nx)
  );

  tl_fast_pair #(.MOD_W(MOD_W), .DEAD(DEAD)) u_fast (
    .clk(clk), .rst(rst), .run(enable),
    .steady(steady_nx), .pos(pos_nx),
    .mod_i(mod_i), .carrier_i(carrier_i),
    .s5_o(s5), .s6_o(s6)
  );

  assign gate_o     = {s6, s5, slow_g};
  assign half_pos_o = half;

endmodule

// File: rtl/tl_leg_sequencer_chk.sv
module tl_leg_sequencer_chk #(
  parameter int MOD_W    = 12,
  parameter int HYST     = 16,
  parameter int SLOW_DLY = 8,
  parameter int DEAD     = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic signed [MOD_W-1:0] mod_i,
  input logic [5:0]              gate_o,
  input logic                    half_pos_o
);

  localparam int CW = $clog2(SLOW_DLY + 2);
  localparam logic [CW-1:0] SAT = CW'(SLOW_DLY);

  logic [CW-1:0] s3_on, s2_on, s1_off, s4_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_on <= '0; s2_on <= '0; s1_off <= '0; s4_off <= '0;
    end else begin
      s3_on  <= gate_o[2]  ? ((s3_on  == SAT) ? SAT : s3_on  + 1'b1) : '0;
      s2_on  <= gate_o[1]  ? ((s2_on  == SAT) ? SAT : s2_on  + 1'b1) : '0;
      s1_off <= !gate_o[0] ? ((s1_off == SAT) ? SAT : s1_off + 1'b1) : '0;
      s4_off <= !gate_o[3] ? ((s4_off == SAT) ? SAT : s4_off + 1'b1) : '0;
    end
  end

  assert_quiet_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (gate_o == 6'd0 && !half_pos_o));

  assert_half_falls_below_band_R2: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && $past(half_pos_o) && !half_pos_o) |-> ($past(mod_i) < -HYST));

  assert_no_leg_short_R4: assert property (@(posedge clk) disable iff (rst)
    !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]) && !(gate_o[4] && gate_o[5]));

  assert_outer_p_after_inner_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o[0]) |-> (s3_on >= SAT));

  assert_outer_n_after_inner_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o[3]) |-> (s2_on >= SAT));

  assert_inner_p_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o[2]) && $past(enable)) |-> (s1_off >= SAT));

  assert_inner_n_release_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate_o[1]) && $past(enable)) |-> (s4_off >= SAT));

  assert_fast_needs_group_R6: assert property (@(posedge clk) disable iff (rst)
    (gate_o[4] || gate_o[5]) |-> ((gate_o[0] && gate_o[2]) || (gate_o[1] && gate_o[3])));

endmodule

bind tl_leg_sequencer tl_leg_sequencer_chk #(
  .MOD_W(MOD_W), .HYST(HYST), .SLOW_DLY(SLOW_DLY), .DEAD(DEAD)
) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .mod_i(mod_i),
  .gate_o(gate_o), .half_pos_o(half_pos_o)
);

// File: tb/tl_leg_sequencer_bench.sv
module tl_leg_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MOD_W = 12;
  localparam int HYST  = 16;
  localparam int SD    = 8;
  localparam int DEAD  = 4;
  localparam int CMAX  = (1 << (MOD_W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic signed [MOD_W-1:0] mod_i = '0;
  logic [MOD_W-2:0] carrier_i = '0;
  logic [5:0] gate_o;
  logic half_pos_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  int rise_at [6];
  int fall_at [6];
  int rise_cnt [6];
  logic [5:0] prev_g = '0;
  int dt_viol = 0, dt_events = 0, grp_viol = 0, pair_viol = 0;

  tl_leg_sequencer #(.MOD_W(MOD_W), .HYST(HYST), .SLOW_DLY(SD), .DEAD(DEAD)) u_tl_leg_sequencer (
    .clk(clk), .rst(rst), .enable(enable), .mod_i(mod_i),
    .carrier_i(carrier_i), .gate_o(gate_o), .half_pos_o(half_pos_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < 6; b++) begin
        if (gate_o[b] && !prev_g[b]) begin rise_at[b] = cyc; rise_cnt[b]++; end
        if (!gate_o[b] && prev_g[b]) fall_at[b] = cyc;
      end
      if (gate_o[5] && !prev_g[5] && fall_at[4] > 0) begin
        dt_events++;
        if (cyc - fall_at[4] < DEAD) dt_viol++;
      end
      if (gate_o[4] && !prev_g[4] && fall_at[5] > 0) begin
        dt_events++;
        if (cyc - fall_at[5] < DEAD) dt_viol++;
      end
      if ((gate_o[4] || gate_o[5]) && !((gate_o[0] && gate_o[2]) || (gate_o[1] && gate_o[3])))
        grp_viol++;
      if ((gate_o[0] && gate_o[1]) || (gate_o[2] && gate_o[3]) || (gate_o[4] && gate_o[5]))
        pair_viol++;
    end
    prev_g = gate_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected fast bits {S6,S5} from R7
  function automatic logic [1:0] exp_fast(input bit pos, input int m, input int c);
    if (pos) return (m > c) ? 2'b01 : 2'b10;
    return (-m > c) ? 2'b10 : 2'b01;
  endfunction

  task automatic fast_case(input bit pos, input int m, input int c, input string tag);
    mod_i = MOD_W'(m);
    carrier_i = (MOD_W-1)'(c);
    tick(DEAD + 3);
    check(gate_o[5:4] == exp_fast(pos, m, c), tag, gate_o[5:4], exp_fast(pos, m, c));
    check(gate_o[3:0] == (pos ? 4'b0101 : 4'b1010), {tag, " R3 group"}, gate_o[3:0],
          pos ? 5 : 10);
  endtask

  initial begin
    int seed_dummy;
    int r2, r4, f1, f4;
    seed_dummy = $urandom(32'd20240611);
    tick(4);
    check(gate_o == 6'd0 && half_pos_o == 1'b0, "R1 reset state", gate_o, 0);
    rst = 1'b0;

    // R1: enable low ignores inputs
    for (int i = 0; i < 6; i++) begin
      mod_i = MOD_W'($urandom);
      carrier_i = (MOD_W-1)'($urandom);
      tick(5);
      check(gate_o == 6'd0 && !half_pos_o, "R1 disabled outputs", {half_pos_o, gate_o}, 0);
    end

    // R2: start from sign, zero counts as positive
    mod_i = '0; carrier_i = '0;
    enable = 1'b1;
    tick(4 * SD + 2 * DEAD + 10);
    check(half_pos_o == 1'b1, "R2 start sign at zero", half_pos_o, 1);
    check(gate_o[3:0] == 4'b0101, "R3 positive group", gate_o[3:0], 5);

    // R7 random positive half
    for (int i = 0; i < 40; i++) begin
      int m, c;
      m = HYST + 1 + int'($urandom % (CMAX - HYST - 1));
      c = int'($urandom % (CMAX + 1));
      fast_case(1'b1, m, c, "R7 random positive");
    end
    fast_case(1'b1, 500, 500, "R7 positive equal carrier");
    fast_case(1'b1, 500, 499, "R7 positive carrier below");

    // R8 exact dead time on an isolated change
    mod_i = 12'sd500; carrier_i = 11'd0; tick(12);
    carrier_i = 11'd1000; tick(12);
    check(rise_at[5] - fall_at[4] == DEAD, "R8 dead gap S5 to S6", rise_at[5] - fall_at[4], DEAD);
    carrier_i = 11'd0; tick(12);
    check(rise_at[4] - fall_at[5] == DEAD, "R8 dead gap S6 to S5", rise_at[4] - fall_at[5], DEAD);

    // R2 band edge does not flip
    mod_i = -MOD_W'(HYST); tick(20);
    check(half_pos_o == 1'b1, "R2 at -HYST holds", half_pos_o, 1);
    check(gate_o[3:0] == 4'b0101, "R2 group held in band", gate_o[3:0], 5);

    // R5 positive to negative order
    mod_i = -MOD_W'(HYST + 1); carrier_i = 11'd2000;
    tick(4 * SD + 2 * DEAD + 10);
    check(half_pos_o == 1'b0, "R2 below band flips", half_pos_o, 0);
    check(fall_at[2] - fall_at[0] == SD, "R5 S1 off to S3 off", fall_at[2] - fall_at[0], SD);
    check(rise_at[1] - fall_at[2] == SD, "R5 S3 off to S2 on", rise_at[1] - fall_at[2], SD);
    check(rise_at[3] - rise_at[1] == SD, "R5 S2 on to S4 on", rise_at[3] - rise_at[1], SD);
    check(gate_o[3:0] == 4'b1010, "R3 negative group", gate_o[3:0], 10);

    // R7 random negative half
    for (int i = 0; i < 40; i++) begin
      int m, c;
      m = -(HYST + 1 + int'($urandom % (CMAX - HYST - 1)));
      c = int'($urandom % (CMAX + 1));
      fast_case(1'b0, m, c, "R7 random negative");
    end
    fast_case(1'b0, -500, 500, "R7 negative equal carrier");
    fast_case(1'b0, -500, 499, "R7 negative carrier below");

    // R2 upper band edge, then R5 negative to positive order
    mod_i = MOD_W'(HYST); tick(20);
    check(half_pos_o == 1'b0, "R2 at +HYST holds", half_pos_o, 0);
    mod_i = MOD_W'(HYST + 1);
    tick(4 * SD + 2 * DEAD + 10);
    check(half_pos_o == 1'b1, "R2 above band flips", half_pos_o, 1);
    check(fall_at[1] - fall_at[3] == SD, "R5 S4 off to S2 off", fall_at[1] - fall_at[3], SD);
    check(rise_at[2] - fall_at[1] == SD, "R5 S2 off to S3 on", rise_at[2] - fall_at[1], SD);
    check(rise_at[0] - rise_at[2] == SD, "R5 S3 on to S1 on", rise_at[0] - rise_at[2], SD);

    // R9 reversal during crossover
    r2 = rise_cnt[1]; r4 = rise_cnt[3]; f1 = fall_at[0]; f4 = rise_cnt[0];
    mod_i = -MOD_W'(HYST + 1);
    tick(3);
    mod_i = MOD_W'(HYST + 1);
    tick(5 * SD + 2 * DEAD + 10);
    check(fall_at[0] != f1, "R9 crossover started", fall_at[0], f1 + 1);
    check(rise_cnt[1] == r2 && rise_cnt[3] == r4, "R9 negative group never on",
          rise_cnt[1] + rise_cnt[3], r2 + r4);
    check(rise_at[2] - fall_at[2] == SD, "R9 gap before re-entry", rise_at[2] - fall_at[2], SD);
    check(rise_cnt[0] == f4 + 1 && gate_o[3:0] == 4'b0101, "R9 back in positive group",
          gate_o[3:0], 5);

    // R1 drop enable in steady state
    enable = 1'b0;
    tick(1);
    check(gate_o == 6'd0 && !half_pos_o, "R1 release within one edge", {half_pos_o, gate_o}, 0);

    // R2 restart inside band takes sign
    mod_i = -12'sd3;
    enable = 1'b1;
    tick(4 * SD + 2 * DEAD + 10);
    check(half_pos_o == 1'b0, "R2 restart negative in band", half_pos_o, 0);
    check(gate_o[3:0] == 4'b1010, "R3 negative after restart", gate_o[3:0], 10);

    check(dt_events > 0 && dt_viol == 0, "R8 dead gap never short", dt_viol, 0);
    check(grp_viol == 0, "R6 fast off during crossover", grp_viol, 0);
    check(pair_viol == 0, "R4 complementary pairs", pair_viol, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule